// File: doc/BRIEF.md
# Per-Line Pedestal Gating Controller

This block follows the line position inside a 525-line interlaced frame and decides, one line at a time, whether the black-level pedestal is applied. It counts line-start strobes and uses field-start strobes to realign. For the sixteen lines at the top of each field's vertical blanking interval, the decision comes from one bit per line. Each field has its own bank of these bits. For all other lines, one global enable bit decides.

The control bits are loaded through a small write port. The result is a single registered flag. It changes only at the beginning of a line, so the downstream level generator sees one constant decision for the whole line.

Top module: `ped_line_gate`

## Requirements
- R1: After reset, `ped_en` is 0, both line banks and the global enable are 0, and the line position is 525, so the first line begin without a first-field start is line 1.
- R2: A line begins on any cycle where `line_start` or `field_start` is high. If `field_start` is high with `field_id` = 0 (first field), the new line is 1. Otherwise the line number goes up by one.
- R3: A `field_start` with `field_id` = 1 (second field) does not realign the count. It acts as an ordinary line begin, so line 263 is followed by 264.
- R4: After line 525 the next line begin gives line 1.
- R5: On lines 10 to 25, `ped_en` equals bit (line − 10) of bank A. Bank A is written with `wr_addr` = 0 and all 16 bits of `wr_data`.
- R6: On lines 273 to 288, `ped_en` equals bit (line − 273) of bank B. Bank B is written with `wr_addr` = 1.
- R7: On every other line, `ped_en` equals the global enable. The global enable is written with `wr_addr` = 2 and takes `wr_data` bit 0.
- R8: `ped_en` changes only on the clock edge where a line begins. It holds its value for the rest of the line.
- R9: A write during a line affects the output only from the next line begin. A write in the same cycle as a line begin is applied at the following line begin.
- R10: A write with `wr_addr` = 3 changes no stored control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| field_start | input | 1 | One-cycle strobe at the start of a field, also a line begin |
| field_id | input | 1 | Field of the field_start strobe: 0 first, 1 second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 bank A, 1 bank B, 2 global, 3 unused |
| wr_data | input | 16 | Write data |
| ped_en | output | 1 | Pedestal enable for the current line |

## Verification
On every cycle, the assertions check the following:
- the line count stays in range, realigns on a first-field start and wraps after 525;
- `ped_en` is quiet between line begins;
- a write to the unused address leaves the stored state untouched.

Only the bench's scenarios can show that:
- the right bank bit is chosen for each line in the two windows;
- the global bit governs all other lines;
- writes are delayed until the next line begin, which the bench checks with writes both mid-line and on a line-begin cycle.

The bench compares `ped_en` against a line-by-line reference model over several frames, including spurious second-field starts.

// File: rtl/ped_pkg.sv
package ped_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_BANK_A = 2'd0,
    SEL_BANK_B = 2'd1,
    SEL_GLOBAL = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ped_line_tracker.sv
module ped_line_tracker #(
  parameter int unsigned TOTAL_LINES = 525,
  parameter int unsigned LINE_W      = $clog2(TOTAL_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              field_start,
  input  logic              field_id,
  output logic              line_begin,
  output logic [LINE_W-1:0] line_nxt,
  output logic [LINE_W-1:0] line_cur
);
  logic realign;

  always_comb begin
    line_begin = line_start | field_start;
    realign    = field_start & ~field_id;
    if (realign)
      line_nxt = LINE_W'(1);
    else if (line_cur == LINE_W'(TOTAL_LINES))
      line_nxt = LINE_W'(1);
    else
      line_nxt = line_cur + LINE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_cur <= LINE_W'(TOTAL_LINES);
    else if (line_begin)
      line_cur <= line_nxt;
  end

  assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cur >= LINE_W'(1)) && (line_cur <= LINE_W'(TOTAL_LINES)));

  assert_first_field_realign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && !field_id) |=> (line_cur == LINE_W'(1)));

  assert_second_field_continues_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (field_start && field_id && line_cur < LINE_W'(TOTAL_LINES))
      |=> (line_cur == $past(line_cur) + LINE_W'(1)));

  assert_wrap_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_begin && !(field_start && !field_id) && line_cur == LINE_W'(TOTAL_LINES))
      |=> (line_cur == LINE_W'(1)));
endmodule

// File: rtl/ped_ctrl_regs.sv
module ped_ctrl_regs
  import ped_pkg::*;
#(
  parameter int unsigned WIN_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WIN_LEN-1:0] wr_data,
  output logic [WIN_LEN-1:0] bank_a,
  output logic [WIN_LEN-1:0] bank_b,
  output logic               glob_en
);
  logic               we_a, we_b, we_g;
  logic [WIN_LEN-1:0] bank_a_d, bank_b_d;
  logic               glob_en_d;

  always_comb begin
    we_a = wr_en && (reg_sel_e'(wr_addr) == SEL_BANK_A);
    we_b = wr_en && (reg_sel_e'(wr_addr) == SEL_BANK_B);
    we_g = wr_en && (reg_sel_e'(wr_addr) == SEL_GLOBAL);
  end

  for (genvar i = 0; i < WIN_LEN; i++) begin : g_bits
    always_comb begin
      bank_a_d[i] = we_a ? wr_data[i] : bank_a[i];
      bank_b_d[i] = we_b ? wr_data[i] : bank_b[i];
    end
  end

  always_comb glob_en_d = we_g ? wr_data[0] : glob_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_a  <= '0;
      bank_b  <= '0;
      glob_en <= 1'b0;
    end else begin
      bank_a  <= bank_a_d;
      bank_b  <= bank_b_d;
      glob_en <= glob_en_d;
    end
  end

  assert_unused_addr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(3))
      |=> ($stable(bank_a) && $stable(bank_b) && $stable(glob_en)));
endmodule

// File: rtl/ped_decide.sv
module ped_decide #(
  parameter int unsigned LINE_W      = 10,
  parameter int unsigned WIN_LEN     = 16,
  parameter int unsigned WIN_A_FIRST = 10,
  parameter int unsigned WIN_B_FIRST = 273
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_begin,
  input  logic [LINE_W-1:0]  line_nxt,
  input  logic [WIN_LEN-1:0] bank_a,
  input  logic [WIN_LEN-1:0] bank_b,
  input  logic               glob_en,
  output logic               ped_en
);
  localparam int unsigned IDX_W = $clog2(WIN_LEN);

  logic [LINE_W-1:0] off_a, off_b;
  logic              in_a, in_b, sel;
  logic [IDX_W-1:0]  idx_a, idx_b;

  always_comb begin
    off_a = line_nxt - LINE_W'(WIN_A_FIRST);
    off_b = line_nxt - LINE_W'(WIN_B_FIRST);
    in_a  = off_a < LINE_W'(WIN_LEN);
    in_b  = off_b < LINE_W'(WIN_LEN);
    idx_a = IDX_W'(off_a);
    idx_b = IDX_W'(off_b);
    if (in_a)
      sel = bank_a[idx_a];
    else if (in_b)
      sel = bank_b[idx_b];
    else
      sel = glob_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ped_en <= 1'b0;
    else if (line_begin)
      ped_en <= sel;
  end

  assert_hold_within_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_begin |=> $stable(ped_en));
endmodule

// File: rtl/ped_line_gate.sv
module ped_line_gate
  import ped_pkg::*;
#(
  parameter int unsigned TOTAL_LINES = 525,
  parameter int unsigned WIN_LEN     = 16,
  parameter int unsigned WIN_A_FIRST = 10,
  parameter int unsigned WIN_B_FIRST = 273
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic               field_start,
  input  logic               field_id,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WIN_LEN-1:0] wr_data,
  output logic               ped_en
);
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES + 1);

  logic               line_begin;
  logic [LINE_W-1:0]  line_nxt, line_cur;
  logic [WIN_LEN-1:0] bank_a, bank_b;
  logic               glob_en;

  ped_line_tracker #(.TOTAL_LINES(TOTAL_LINES), .LINE_W(LINE_W)) u_track (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
    .field_id(field_id), .line_begin(line_begin), .line_nxt(line_nxt), .line_cur(line_cur)
  );

  ped_ctrl_regs #(.WIN_LEN(WIN_LEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_a(bank_a), .bank_b(bank_b), .glob_en(glob_en)
  );

  ped_decide #(.LINE_W(LINE_W), .WIN_LEN(WIN_LEN), .WIN_A_FIRST(WIN_A_FIRST),
               .WIN_B_FIRST(WIN_B_FIRST)) u_dec (
    .clk(clk), .rst_n(rst_n), .line_begin(line_begin), .line_nxt(line_nxt),
    .bank_a(bank_a), .bank_b(bank_b), .glob_en(glob_en), .ped_en(ped_en)
  );
endmodule

// File: tb/test_ped_line_gate.sv
module test_ped_line_gate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0, field_start = 1'b0, field_id = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ped_en;

  int checks = 0, errors = 0;
  int m_line = 525;
  logic [15:0] m_a = '0, m_b = '0;
  logic m_g = 1'b0, m_ped = 1'b0;
  bit m_begin_last = 1'b0;
  bit done = 1'b0;

  ped_line_gate i_ped_line_gate (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_start(field_start),
    .field_id(field_id), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ped_en(ped_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_ped(int line, logic [15:0] a, logic [15:0] b, logic g);
    if (line >= 10 && line <= 25) return a[line-10];
    if (line >= 273 && line <= 288) return b[line-273];
    return g;
  endfunction

  function automatic string tag_of(int line, bit began);
    if (!began) return "R8";
    if (line >= 10 && line <= 25) return "R5";
    if (line >= 273 && line <= 288) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s line %0d: ped_en=%0b expected %0b", req, m_line, act, exp);
    end
  endtask

  // One cycle: check the result of the previous edge, drive new inputs, update the model.
  task automatic step(bit ls, bit fs, bit fid, bit we, logic [1:0] ad, logic [15:0] d,
                      string req = "");
    @(negedge clk);
    check(req == "" ? tag_of(m_line, m_begin_last) : req, ped_en, m_ped);
    line_start = ls; field_start = fs; field_id = fid;
    wr_en = we; wr_addr = ad; wr_data = d;
    m_begin_last = ls | fs;
    if (ls | fs) begin
      if (fs && !fid) m_line = 1;
      else m_line = (m_line == 525) ? 1 : m_line + 1;
      m_ped = exp_ped(m_line, m_a, m_b, m_g);
    end
    if (we) begin
      case (ad)
        2'd0: m_a = d;
        2'd1: m_b = d;
        2'd2: m_g = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'd0, 16'd0);
  endtask

  // One line with a field start where the raster expects one, random writes inside.
  task automatic random_line();
    bit fs;
    bit fid;
    fs  = (m_line == 525) || (m_line == 263);
    fid = (m_line == 263);
    if (!fs && ($urandom % 97) == 0) begin fs = 1; fid = 1; end  // spurious second-field start, R3
    step(!fs, fs, fid, ($urandom % 8) == 0, 2'($urandom % 4), 16'($urandom));
    for (int i = 0; i < 2 + int'($urandom % 3); i++)
      step(0, 0, 0, ($urandom % 6) == 0, 2'($urandom % 4), 16'($urandom));
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1", ped_en, 1'b0);
    rst_n = 1'b1;
    idle(2);

    // R1/R4: first line begin after reset, no field start, yields line 1 -> global (0)
    step(1, 0, 0, 0, 2'd0, 16'd0, "R1");
    // R7/R9: set global mid-line, visible only at next line begin
    step(0, 0, 0, 1, 2'd2, 16'h0001);
    idle(2);
    check("R9", ped_en, 1'b0);
    step(1, 0, 0, 0, 2'd0, 16'd0, "R9");   // line 2 begins
    idle(1);
    check("R7", ped_en, 1'b1);
    // R10: write to unused address must not disturb anything
    step(0, 0, 0, 1, 2'd3, 16'h0000, "R10");
    step(1, 0, 0, 0, 2'd0, 16'd0, "R10");  // line 3
    idle(1);
    check("R10", ped_en, 1'b1);
    // R9: write on a line-begin cycle applies one line later
    step(1, 0, 0, 1, 2'd2, 16'h0000, "R9"); // line 4, global cleared same edge
    idle(1);
    check("R9", ped_en, 1'b1);
    step(1, 0, 0, 0, 2'd0, 16'd0, "R9");    // line 5
    idle(1);
    check("R9", ped_en, 1'b0);

    // Bank patterns, then realign to line 1 and walk frames
    step(0, 0, 0, 1, 2'd0, 16'hA5C3);
    step(0, 0, 0, 1, 2'd1, 16'h3C96);
    step(0, 0, 0, 1, 2'd2, 16'h0001);
    step(0, 1, 0, 0, 2'd0, 16'd0, "R2");    // first-field start -> line 1
    idle(1);
    for (int f = 0; f < 4; f++)
      for (int l = 0; l < 525; l++) random_line();
    idle(2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule